// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a two-wire serial slave that lets a host read and write a bank of 22 eight-bit configuration registers. It oversamples the clock and data lines on the system clock, finds START and STOP conditions, and runs block and byte-data transfers. The slave answers at the 8-bit address 0xD2 for writes and 0xD3 for reads. Open-drain behaviour is modelled with a single pull-low enable: when `sda_oe_o` is high, the pad pulls the data line low.

The command byte selects how registers are addressed. A command of 0x00 starts a block transfer. In a block write the next byte is a count, and the data bytes after it fill the registers from index 0 upwards. In a block read the slave sends the bank size first and then the registers in ascending order. Any command k from 1 to 22 selects byte-data access to register k-1, so a register's byte-data number is always one higher than its block position. The register bank sits outside this block. It receives a one-cycle write strobe with an index and data, and returns read data for the index the block presents. Reset values and read-only fields belong to the bank.

Top module: `smb_regif`

## Requirements
- R1: The slave ACKs address byte 0xD2 (write) and 0xD3 (read). Any other address byte is NACKed, causes no write, and leaves SDA undriven until the next START.
- R2: In a write with command k (1 to 22), the command and the next data byte are ACKed, and that data byte is written to register index k-1.
- R3: In a write with command 0x00, the next byte is a count N. The following N data bytes are ACKed and written to indices 0, 1, 2 and onwards. The byte after the N-th is NACKed and not written.
- R4: After command 0x00, a repeated START and address 0xD3, the slave sends 22 (0x16), then registers 0 to 21 in order, then 0xFF for every further byte the master acknowledges.
- R5: After command k (1 to 22), a repeated START and address 0xD3, the first byte sent is the content of register k-1.
- R6: A command byte above 22 is NACKed, and nothing is written.
- R7: In a block write, a data byte that would land at index 22 or higher is NACKed, and no write strobe ever carries an index of 22 or more.
- R8: A STOP or START that arrives before a data byte is complete discards that byte with no write. A repeated START begins a new address phase and keeps the last command for a read.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: While reset is held, and after it is released, SDA is undriven and the write strobe is low.
- R11: Each accepted data byte raises the write strobe for exactly one clock, in the same cycle that the slave starts driving the ACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High to pull the data line low |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_widx_o | output | 5 | Register index for the write |
| reg_wdata_o | output | 8 | Register data for the write |
| reg_ridx_o | output | 5 | Register index being read |
| reg_rdata_i | input | 8 | Read data returned by the bank for `reg_ridx_o` |

## Verification
If the read pointer or the count phase is wrong, the first byte clocked out after the address ACK is wrong, or the ascending sequence of a block read shifts. The bench compares every byte of a full block read, so such an error shows within one byte time. If the role or the remaining-count tracking is wrong, an ACK is misplaced or a stray write strobe appears. The bench sees this at the ACK slot of the byte concerned, and again through the count of strobes, which it compares after each transfer. If a partial byte is committed after STOP or repeated START, the read-back of the untouched register on the next transfer shows it.

// File: rtl/smb_regif_pkg.sv
package smb_regif_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_DATA
  } rx_role_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic scl;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det
  import smb_regif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic scl_s, sda_s, scl_q, sda_q;

  smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // start/stop only while SCL held high across both samples
  assign ev_o.start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_o.rise  = scl_s & ~scl_q;
  assign ev_o.fall  = ~scl_s & scl_q;
  assign ev_o.scl   = scl_s;
  assign ev_o.sda   = sda_s;

endmodule

// File: rtl/smb_regif.sv
module smb_regif
  import smb_regif_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 22,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             reg_we_o,
  output logic [IDX_W-1:0] reg_widx_o,
  output logic [7:0]       reg_wdata_o,
  output logic [IDX_W-1:0] reg_ridx_o,
  input  logic [7:0]       reg_rdata_i
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);
  localparam logic [7:0]       NREG_B   = 8'(NUM_REGS);

  bus_ev_t    ev;
  smb_state_e state_q;
  rx_role_e   role_q;
  logic [2:0] bit_cnt_q;
  logic       byte_full_q, go_tx_q, cnt_phase_q, oe_q, we_q;
  logic [7:0] rx_sh_q, tx_sh_q, cmd_q, rem_q, wdata_q;
  logic [IDX_W-1:0] ptr_q, widx_q;

  logic             ack_now, blk_cmd;
  logic [7:0]       tx_next;
  logic [IDX_W-1:0] ptr_inc, cmd_idx, rx_idx;

  smb_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  assign blk_cmd = (cmd_q == 8'd0);
  assign cmd_idx = IDX_W'(cmd_q - 8'd1);
  assign rx_idx  = IDX_W'(rx_sh_q - 8'd1);
  assign ptr_inc = (ptr_q < LAST_IDX) ? ptr_q + IDX_W'(1) : ptr_q;
  assign tx_next = cnt_phase_q ? NREG_B : ((ptr_q < LAST_IDX) ? reg_rdata_i : 8'hFF);

  always_comb begin
    unique case (role_q)
      RL_ADDR: ack_now = (rx_sh_q[7:1] == DEV_ADDR);
      RL_CMD:  ack_now = (rx_sh_q <= NREG_B);
      RL_CNT:  ack_now = 1'b1;
      default: ack_now = (rem_q != 8'd0) && (ptr_q < LAST_IDX);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      role_q      <= RL_ADDR;
      bit_cnt_q   <= '0;
      byte_full_q <= 1'b0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      go_tx_q     <= 1'b0;
      cmd_q       <= '0;
      ptr_q       <= '0;
      rem_q       <= '0;
      cnt_phase_q <= 1'b0;
      oe_q        <= 1'b0;
      we_q        <= 1'b0;
      widx_q      <= '0;
      wdata_q     <= '0;
    end else begin
      we_q <= 1'b0;
      if (ev.start) begin
        state_q     <= ST_RX;
        role_q      <= RL_ADDR;
        bit_cnt_q   <= '0;
        byte_full_q <= 1'b0;
        oe_q        <= 1'b0;
      end else if (ev.stop) begin
        state_q     <= ST_IDLE;
        byte_full_q <= 1'b0;
        oe_q        <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (ev.rise) begin
              rx_sh_q   <= {rx_sh_q[6:0], ev.sda};
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) byte_full_q <= 1'b1;
            end else if (ev.fall && byte_full_q) begin
              byte_full_q <= 1'b0;
              if (!ack_now) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_RX_ACK;
                oe_q    <= 1'b1;
                unique case (role_q)
                  RL_ADDR: begin
                    go_tx_q <= rx_sh_q[0];
                    if (rx_sh_q[0]) begin
                      cnt_phase_q <= blk_cmd;
                      ptr_q       <= blk_cmd ? '0 : cmd_idx;
                    end else begin
                      role_q <= RL_CMD;
                    end
                  end
                  RL_CMD: begin
                    go_tx_q <= 1'b0;
                    cmd_q   <= rx_sh_q;
                    if (rx_sh_q == 8'd0) begin
                      role_q <= RL_CNT;
                    end else begin
                      role_q <= RL_DATA;
                      ptr_q  <= rx_idx;
                      rem_q  <= 8'd1;
                    end
                  end
                  RL_CNT: begin
                    go_tx_q <= 1'b0;
                    rem_q   <= rx_sh_q;
                    ptr_q   <= '0;
                    role_q  <= RL_DATA;
                  end
                  default: begin
                    go_tx_q <= 1'b0;
                    we_q    <= 1'b1;
                    widx_q  <= ptr_q;
                    wdata_q <= rx_sh_q;
                    ptr_q   <= ptr_q + IDX_W'(1);
                    rem_q   <= rem_q - 8'd1;
                  end
                endcase
              end
            end
          end
          ST_RX_ACK: begin
            if (ev.fall) begin
              bit_cnt_q <= '0;
              if (go_tx_q) begin
                state_q <= ST_TX;
                tx_sh_q <= tx_next;
                oe_q    <= ~tx_next[7];
                if (cnt_phase_q) cnt_phase_q <= 1'b0;
                else             ptr_q       <= ptr_inc;
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (ev.fall) begin
              if (bit_cnt_q == 3'd7) begin
                oe_q    <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
                oe_q      <= ~tx_sh_q[6];
                bit_cnt_q <= bit_cnt_q + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (ev.rise && ev.sda) begin
              state_q <= ST_IDLE;   // master NACK ends the read
            end else if (ev.fall) begin
              state_q   <= ST_TX;
              bit_cnt_q <= '0;
              tx_sh_q   <= tx_next;
              oe_q      <= ~tx_next[7];
              if (cnt_phase_q) cnt_phase_q <= 1'b0;
              else             ptr_q       <= ptr_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_widx_o  = widx_q;
  assign reg_wdata_o = wdata_q;
  assign reg_ridx_o  = ptr_q;

  AST_WE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_widx_o < LAST_IDX)); // R7
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R11
  AST_WE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sda_oe_o); // R11
  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev.scl && $past(ev.scl)) |-> $stable(sda_oe_o)); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.stop |=> !sda_oe_o); // R8
  AST_NO_WE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.stop |=> !reg_we_o); // R8

endmodule

// File: tb/smb_regif_test.sv
module smb_regif_test;

  localparam int unsigned NREG = 22;
  localparam int unsigned IW   = 5;
  localparam int          Q    = 8;
  localparam logic [15:0] VEC [6] = '{16'h01A5, 16'h163C, 16'h0B5A,
                                      16'h0201, 16'h0AFF, 16'h1580};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_oe = 1'b0;
  logic sda;
  logic s_oe, we;
  logic [IW-1:0] widx, ridx;
  logic [7:0] wdata, rdata;

  logic [7:0] bank [NREG];
  logic [7:0] exp_m [NREG];
  int n_chk = 0, n_err = 0, we_cnt = 0, exp_we = 0, r9_viol = 0, r11_viol = 0;
  logic scl_d = 1'b1, oe_d = 1'b0, we_d = 1'b0;

  always #2 clk = ~clk;

  assign sda   = ~(m_oe | s_oe);
  assign rdata = (ridx < IW'(NREG)) ? bank[ridx] : 8'h00;

  smb_regif uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda),
    .sda_oe_o   (s_oe),
    .reg_we_o   (we),
    .reg_widx_o (widx),
    .reg_wdata_o(wdata),
    .reg_ridx_o (ridx),
    .reg_rdata_i(rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= 8'h00;
    end else if (we && widx < IW'(NREG)) begin
      bank[widx] <= wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (we) we_cnt++;
      if (we && we_d) r11_viol++;
      if (scl && scl_d && (s_oe != oe_d)) r9_viol++;
    end
    scl_d <= scl;
    oe_d  <= s_oe;
    we_d  <= we;
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic q_wait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_oe = 1'b0; q_wait; scl = 1'b1; q_wait;
    m_oe = 1'b1; q_wait; scl = 1'b0; q_wait;
  endtask

  task automatic bus_stop;
    m_oe = 1'b1; q_wait; scl = 1'b1; q_wait;
    m_oe = 1'b0; q_wait; q_wait;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_oe = ~b[i]; q_wait; scl = 1'b1; q_wait; q_wait; scl = 1'b0; q_wait;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_oe = 1'b0; q_wait; scl = 1'b1; q_wait;
    ack = (sda == 1'b0);
    q_wait; scl = 1'b0; q_wait;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic [7:0] t;
    m_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q_wait; scl = 1'b1; q_wait; t[i] = sda; q_wait; scl = 1'b0;
    end
    m_oe = mack; q_wait; scl = 1'b1; q_wait; q_wait; scl = 1'b0; q_wait;
    m_oe = 1'b0;
    b = t;
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; send_byte(8'hD2, a0); send_byte(cmd, a1);
    bus_start; send_byte(8'hD3, a2); recv_byte(1'b0, d); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic a0, a1, a2, ok;
    logic [7:0] rb, c, d;
    for (int i = 0; i < NREG; i++) exp_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R10 oe in reset", int'(s_oe), 0);
    chk("R10 we in reset", int'(we), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 oe after reset", int'(s_oe), 0);
    chk("R10 no strobe", we_cnt, 0);

    // byte-data write then read back, table driven
    for (int i = 0; i < 6; i++) begin
      c = VEC[i][15:8]; d = VEC[i][7:0];
      bus_start; send_byte(8'hD2, a0); send_byte(c, a1); send_byte(d, a2); bus_stop;
      chk("R1 addr ack", int'(a0), 1);
      chk("R2 cmd ack", int'(a1), 1);
      chk("R2 data ack", int'(a2), 1);
      exp_m[int'(c) - 1] = d; exp_we++;
      chk("R2 bank at k-1", int'(bank[int'(c) - 1]), int'(d));
      byte_read(c, rb, ok);
      chk("R5 acks", int'(ok), 1);
      chk("R5 read data", int'(rb), int'(d));
    end
    chk("R11 strobe count", we_cnt, exp_we);

    // block write, count 4, then an extra byte
    bus_start; send_byte(8'hD2, a0); send_byte(8'h00, a1); send_byte(8'd4, a2);
    chk("R3 cmd/count ack", int'(a1 & a2), 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h11 * (i + 1), a0);
      chk("R3 data ack", int'(a0), 1);
      exp_m[i] = 8'h11 * (i + 1); exp_we++;
    end
    send_byte(8'h55, a0);
    chk("R3 byte past count NACK", int'(a0), 0);
    bus_stop;
    chk("R3 strobe count", we_cnt, exp_we);

    // block write running past the last register
    bus_start; send_byte(8'hD2, a0); send_byte(8'h00, a1); send_byte(8'd30, a2);
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'h40 + 8'(i), a0);
      if (a0 != 1'b1) chk("R7 in-range ack", int'(a0), 1);
      exp_m[i] = 8'h40 + 8'(i); exp_we++;
    end
    send_byte(8'hEE, a0);
    chk("R7 overflow NACK", int'(a0), 0);
    bus_stop;
    chk("R7 strobe count", we_cnt, exp_we);

    // block read
    bus_start; send_byte(8'hD2, a0); send_byte(8'h00, a1);
    bus_start; send_byte(8'hD3, a2);
    chk("R4 acks", int'(a0 & a1 & a2), 1);
    recv_byte(1'b1, rb);
    chk("R4 count byte", int'(rb), int'(NREG));
    for (int i = 0; i < NREG; i++) begin
      recv_byte(1'b1, rb);
      if (rb != exp_m[i]) chk("R4 block data", int'(rb), int'(exp_m[i]));
      else n_chk++;
    end
    recv_byte(1'b0, rb);
    chk("R4 past end", int'(rb), 8'hFF);
    bus_stop;

    // wrong address
    bus_start; send_byte(8'hA4, a0); send_byte(8'h03, a1); send_byte(8'h77, a2); bus_stop;
    chk("R1 wrong addr NACK", int'(a0), 0);
    chk("R1 no follow ack", int'(a1 | a2), 0);
    chk("R1 no strobe", we_cnt, exp_we);
    chk("R1 sda released", int'(s_oe), 0);

    // command out of range
    bus_start; send_byte(8'hD2, a0); send_byte(8'd23, a1); send_byte(8'h66, a2); bus_stop;
    chk("R6 cmd NACK", int'(a1), 0);
    chk("R6 no strobe", we_cnt, exp_we);

    // STOP inside a data byte
    bus_start; send_byte(8'hD2, a0); send_byte(8'd5, a1); send_bits(8'h0F, 4); bus_stop;
    chk("R8 stop no strobe", we_cnt, exp_we);
    byte_read(8'd5, rb, ok);
    chk("R8 reg kept after stop", int'(rb), int'(exp_m[4]));

    // repeated START inside a data byte, then read with stored command
    bus_start; send_byte(8'hD2, a0); send_byte(8'd6, a1); send_bits(8'hC3, 3);
    bus_start; send_byte(8'hD3, a2); recv_byte(1'b0, rb); bus_stop;
    chk("R8 restart read ack", int'(a2), 1);
    chk("R8 restart read data", int'(rb), int'(exp_m[5]));
    chk("R8 restart no strobe", we_cnt, exp_we);

    chk("R9 sda change while scl high", r9_viol, 0);
    chk("R11 strobe one cycle", r11_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule